// File: doc/BRIEF.md
# GPIO and Shift Command Parser

This block sits on a byte stream of commands. It takes each opcode, gathers the operand bytes that opcode calls for, and then acts on it. Two 8-bit pin groups, low and high, can be set or read back. Setting a group takes a value byte and a direction byte. Reading a group returns one byte on an output stream. A loopback flag is switched on and off by two opcodes.

Opcodes with the top bit clear are data-shift commands. The parser collects their length field and hands the command to an external shift engine through a valid/ready dispatch port. While that engine reports busy, the parser keeps input ready low, so the engine can take any data bytes from the shared input stream. Any other opcode is answered with an error byte followed by the opcode itself. The parser then treats the next byte as a fresh opcode.

Both byte streams use valid/ready. A byte moves on a rising edge where valid and ready are both high. A source holds valid and its data steady until the byte is taken. The parser never takes a new opcode while a response byte is still waiting. It holds its output byte steady while the receiver keeps ready low.

Top module: `gpcmd_parser`

## Requirements
- R1: After synchronous reset: in_ready is 1, out_valid is 0, sh_valid is 0, loop_en is 0, and every pin value and direction output is 0.
- R2: Opcode 0x80 is followed by a value byte and then a direction byte. On the edge that takes the direction byte, lo_out and lo_oe both update. A direction bit of 1 drives that pin with its value bit; a direction bit of 0 leaves it tristated.
- R3: Opcode 0x82 sets hi_out and hi_oe in the same way, also with the value byte first and the direction byte second.
- R4: Opcodes 0x81 and 0x83 take no operands. Each produces exactly one output byte: lo_pins or hi_pins, as sampled on the edge that takes the opcode.
- R5: An opcode below 0x80 with bit 1 clear is a byte-mode shift. Its length comes as an LSB byte and then an MSB byte. After both arrive, sh_valid rises with sh_op equal to the opcode and sh_len equal to {MSB, LSB}.
- R6: An opcode below 0x80 with bit 1 set is a bit-mode shift. It takes a single length byte, and sh_len is that byte with the upper byte zero.
- R7: sh_valid, sh_op and sh_len hold until sh_ready is high. After the handoff, in_ready stays low until a cycle in which sh_busy is low. The engine must raise sh_busy in the cycle after the handoff.
- R8: Opcode 0x84 sets loop_en to 1, and opcode 0x85 clears it.
- R9: Any opcode from 0x86 to 0xFF produces two output bytes, 0xFA and then the opcode. The byte that follows is decoded as an opcode.
- R10: While out_valid is high and out_ready is low, out_data stays stable. in_ready stays low while any response byte is still pending.
- R11: Operand bytes are never decoded as opcodes. For example, a value byte of 0x85 leaves loop_en unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Command byte valid |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Parser accepts a byte |
| out_valid | output | 1 | Response byte valid |
| out_data | output | 8 | Response byte |
| out_ready | input | 1 | Receiver accepts the response byte |
| lo_pins | input | 8 | Sensed levels of the low pin group |
| hi_pins | input | 8 | Sensed levels of the high pin group |
| lo_out | output | 8 | Low group drive values |
| lo_oe | output | 8 | Low group output enables (1 = drive) |
| hi_out | output | 8 | High group drive values |
| hi_oe | output | 8 | High group output enables (1 = drive) |
| loop_en | output | 1 | Loopback flag |
| sh_valid | output | 1 | Shift command offered to the engine |
| sh_ready | input | 1 | Engine takes the shift command |
| sh_op | output | 8 | Shift opcode |
| sh_len | output | 16 | Shift length field |
| sh_busy | input | 1 | Engine running; input stalls while high |

## Verification
Directed frames come first. They set each pin group with distinct value and direction patterns, read each group while the response receiver applies back-pressure, and issue byte-mode and bit-mode shifts. These show whether the operand counts and the length byte order are correct. Operand bytes that look like loopback opcodes (0x84, 0x85) show whether the parser mistakes operand bytes for opcodes. Back-to-back unknown opcodes followed by a read show whether the parser resynchronises. A pseudo-random byte stream then mixes every frame type with toggling dispatch and output ready. Throughout, a behavioural queue model of the parser is compared against every output on every clock.

// File: rtl/gpcmd_pkg.sv
package gpcmd_pkg;
  localparam int NPORT = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEN0,
    ST_LEN1,
    ST_VAL,
    ST_DIR,
    ST_SHIFT,
    ST_ENG
  } st_e;

  typedef enum logic [2:0] {
    K_SHIFT,
    K_SETPIN,
    K_GETPIN,
    K_LOOP,
    K_BAD
  } kind_e;
endpackage

// File: rtl/gpcmd_decode.sv
module gpcmd_decode
  import gpcmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] op,
  output kind_e             kind,
  output logic              port,
  output logic              bitmode,
  output logic              loop_val
);
  always_comb begin
    kind     = K_BAD;
    port     = op[1];
    bitmode  = op[1];
    loop_val = ~op[0];
    if (!op[DATA_W-1]) begin
      kind = K_SHIFT;
    end else if (op[DATA_W-2:3] == '0) begin
      case (op[2:0])
        3'd0, 3'd2: kind = K_SETPIN;
        3'd1, 3'd3: kind = K_GETPIN;
        3'd4, 3'd5: kind = K_LOOP;
        default:    kind = K_BAD;
      endcase
    end
  end
endmodule

// File: rtl/gpcmd_pinreg.sv
module gpcmd_pinreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] val,
  input  logic [W-1:0] dir,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
    end else if (we) begin
      pin_out <= val;
      pin_oe  <= dir;
    end
  end
endmodule

// File: rtl/gpcmd_resp.sv
module gpcmd_resp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         two,
  input  logic [W-1:0] first,
  input  logic [W-1:0] second,
  output logic         busy,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  logic [1:0]   cnt;
  logic [W-1:0] hd, tl;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      hd  <= '0;
      tl  <= '0;
    end else if (load) begin
      cnt <= two ? 2'd2 : 2'd1;
      hd  <= first;
      tl  <= second;
    end else if (cnt != 2'd0 && out_ready) begin
      cnt <= cnt - 2'd1;
      hd  <= tl;
    end
  end

  assign busy      = (cnt != 2'd0);
  assign out_valid = busy;
  assign out_data  = hd;
endmodule

// File: rtl/gpcmd_parser.sv
module gpcmd_parser
  import gpcmd_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  ERR_CODE = 8'hFA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  input  logic [DATA_W-1:0] lo_pins,
  input  logic [DATA_W-1:0] hi_pins,
  output logic [DATA_W-1:0] lo_out,
  output logic [DATA_W-1:0] lo_oe,
  output logic [DATA_W-1:0] hi_out,
  output logic [DATA_W-1:0] hi_oe,
  output logic              loop_en,
  output logic              sh_valid,
  input  logic              sh_ready,
  output logic [DATA_W-1:0] sh_op,
  output logic [2*DATA_W-1:0] sh_len,
  input  logic              sh_busy
);
  localparam int LEN_W = 2 * DATA_W;

  st_e                st;
  logic [DATA_W-1:0]  op_q, val_q;
  logic [LEN_W-1:0]   len_q;
  logic               port_q, bm_q, loop_q;
  logic               take, resp_busy, resp_load, resp_two;
  logic [DATA_W-1:0]  resp_first;
  kind_e              kind;
  logic               dec_port, dec_bm, dec_loop;
  logic [DATA_W-1:0]  pout [NPORT];
  logic [DATA_W-1:0]  poe  [NPORT];

  gpcmd_decode #(.DATA_W(DATA_W)) u_dec (
    .op(in_data), .kind(kind), .port(dec_port),
    .bitmode(dec_bm), .loop_val(dec_loop)
  );

  always_comb begin
    case (st)
      ST_IDLE:                         in_ready = !resp_busy;
      ST_LEN0, ST_LEN1, ST_VAL, ST_DIR: in_ready = 1'b1;
      default:                         in_ready = 1'b0;
    endcase
  end

  assign take = in_valid && in_ready;

  // Response loading: one sampled byte for a read, two for an unknown opcode.
  assign resp_load  = take && (st == ST_IDLE) && (kind == K_GETPIN || kind == K_BAD);
  assign resp_two   = (kind == K_BAD);
  assign resp_first = (kind == K_BAD) ? ERR_CODE[DATA_W-1:0]
                    : (dec_port ? hi_pins : lo_pins);

  gpcmd_resp #(.W(DATA_W)) u_resp (
    .clk(clk), .rst(rst), .load(resp_load), .two(resp_two),
    .first(resp_first), .second(in_data), .busy(resp_busy),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  // One value/direction register pair per pin group.
  for (genvar g = 0; g < NPORT; g++) begin : g_port
    logic we_g;
    assign we_g = take && (st == ST_DIR) && (port_q == 1'(g));
    gpcmd_pinreg #(.W(DATA_W)) u_pins (
      .clk(clk), .rst(rst), .we(we_g), .val(val_q), .dir(in_data),
      .pin_out(pout[g]), .pin_oe(poe[g])
    );
  end

  assign lo_out = pout[0];
  assign lo_oe  = poe[0];
  assign hi_out = pout[1];
  assign hi_oe  = poe[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      op_q   <= '0;
      val_q  <= '0;
      len_q  <= '0;
      port_q <= 1'b0;
      bm_q   <= 1'b0;
      loop_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (take) begin
          op_q   <= in_data;
          port_q <= dec_port;
          bm_q   <= dec_bm;
          case (kind)
            K_SHIFT:  st <= ST_LEN0;
            K_SETPIN: st <= ST_VAL;
            K_LOOP:   loop_q <= dec_loop;
            default:  st <= ST_IDLE;
          endcase
        end
        ST_LEN0: if (take) begin
          len_q <= {{DATA_W{1'b0}}, in_data};
          st    <= bm_q ? ST_SHIFT : ST_LEN1;
        end
        ST_LEN1: if (take) begin
          len_q[LEN_W-1:DATA_W] <= in_data;
          st <= ST_SHIFT;
        end
        ST_VAL: if (take) begin
          val_q <= in_data;
          st    <= ST_DIR;
        end
        ST_DIR:   if (take) st <= ST_IDLE;
        ST_SHIFT: if (sh_ready) st <= ST_ENG;
        ST_ENG:   if (!sh_busy) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assign sh_valid = (st == ST_SHIFT);
  assign sh_op    = op_q;
  assign sh_len   = len_q;
  assign loop_en  = loop_q;
endmodule

// File: rtl/gpcmd_parser_chk.sv
module gpcmd_parser_chk #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [DATA_W-1:0]   out_data,
  input logic                sh_valid,
  input logic                sh_ready,
  input logic [DATA_W-1:0]   sh_op,
  input logic [2*DATA_W-1:0] sh_len,
  input logic [DATA_W-1:0]   lo_out,
  input logic [DATA_W-1:0]   lo_oe,
  input logic [DATA_W-1:0]   hi_out,
  input logic [DATA_W-1:0]   hi_oe,
  input logic                loop_en
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10

  AST_NO_TAKE_WHILE_RESP: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready); // R10

  AST_DISPATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    sh_valid && !sh_ready |=> sh_valid && $stable(sh_op) && $stable(sh_len)); // R7

  AST_STALL_ON_DISPATCH: assert property (@(posedge clk) disable iff (rst)
    sh_valid |-> !in_ready); // R7

  AST_SHIFT_OP_RANGE: assert property (@(posedge clk) disable iff (rst)
    sh_valid |-> !sh_op[DATA_W-1]); // R5

  AST_STATE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(lo_out) && $stable(lo_oe) &&
      $stable(hi_out) && $stable(hi_oe) && $stable(loop_en)); // R2
endmodule

bind gpcmd_parser gpcmd_parser_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .sh_valid(sh_valid), .sh_ready(sh_ready), .sh_op(sh_op), .sh_len(sh_len),
  .lo_out(lo_out), .lo_oe(lo_oe), .hi_out(hi_out), .hi_oe(hi_oe),
  .loop_en(loop_en)
);

// File: tb/gpcmd_parser_tb.sv
module gpcmd_parser_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b1;
  logic [7:0]  lo_pins = 8'h00;
  logic [7:0]  hi_pins = 8'h00;
  logic [7:0]  lo_out, lo_oe, hi_out, hi_oe;
  logic        loop_en;
  logic        sh_valid;
  logic        sh_ready = 1'b1;
  logic [7:0]  sh_op;
  logic [15:0] sh_len;
  logic        sh_busy;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit out_bp = 1'b0;
  bit done = 1'b0;

  gpcmd_parser u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .lo_pins(lo_pins), .hi_pins(hi_pins),
    .lo_out(lo_out), .lo_oe(lo_oe), .hi_out(hi_out), .hi_oe(hi_oe),
    .loop_en(loop_en), .sh_valid(sh_valid), .sh_ready(sh_ready),
    .sh_op(sh_op), .sh_len(sh_len), .sh_busy(sh_busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Shift engine stand-in: busy from the cycle after handoff, for three cycles.
  int eng_cnt;
  always @(posedge clk) begin
    if (rst) begin
      sh_busy <= 1'b0;
      eng_cnt <= 0;
    end else if (sh_valid && sh_ready) begin
      sh_busy <= 1'b1;
      eng_cnt <= 3;
    end else if (eng_cnt > 0) begin
      eng_cnt <= eng_cnt - 1;
      if (eng_cnt == 1) sh_busy <= 1'b0;
    end
  end

  // Ready patterns on both downstream sides.
  always @(negedge clk) begin
    cyc++;
    sh_ready  = (cyc % 4) != 1;
    out_ready = out_bp ? ((cyc % 3) == 0) : 1'b1;
  end

  // Behavioural reference model.
  int         m_need;
  bit         m_disp, m_eng, m_loop;
  logic [7:0] m_op, m_val, m_a0;
  logic [15:0] m_len;
  logic [7:0] m_lo, m_loe, m_hi, m_hoe;
  logic [7:0] m_rq[$];

  function automatic bit m_ready();
    return !m_disp && !m_eng && (m_need > 0 || m_rq.size() == 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_need = 0; m_disp = 0; m_eng = 0; m_loop = 0;
      m_op = 0; m_val = 0; m_a0 = 0; m_len = 0;
      m_lo = 0; m_loe = 0; m_hi = 0; m_hoe = 0;
      m_rq.delete();
    end else begin
      bit acc;
      acc = in_valid && m_ready();
      if (m_rq.size() > 0 && out_ready) void'(m_rq.pop_front());
      if (m_disp && sh_ready) begin
        m_disp = 0;
        m_eng  = 1;
      end else if (m_eng && !sh_busy) begin
        m_eng = 0;
      end
      if (acc) begin
        if (m_need == 0) begin
          m_op = in_data;
          if (in_data < 8'h80) m_need = in_data[1] ? 1 : 2;
          else if (in_data == 8'h80 || in_data == 8'h82) m_need = 2;
          else if (in_data == 8'h81) m_rq.push_back(lo_pins);
          else if (in_data == 8'h83) m_rq.push_back(hi_pins);
          else if (in_data == 8'h84) m_loop = 1;
          else if (in_data == 8'h85) m_loop = 0;
          else begin
            m_rq.push_back(8'hFA);
            m_rq.push_back(in_data);
          end
        end else begin
          m_need--;
          if (m_op < 8'h80) begin
            if (m_op[1]) begin
              m_len = {8'h00, in_data};
              m_disp = 1;
            end else if (m_need == 1) begin
              m_a0 = in_data;
            end else begin
              m_len = {in_data, m_a0};
              m_disp = 1;
            end
          end else if (m_need == 1) begin
            m_val = in_data;
          end else if (m_op == 8'h80) begin
            m_lo = m_val; m_loe = in_data;
          end else begin
            m_hi = m_val; m_hoe = in_data;
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      vectors++;
      chk("R10", "in_ready", 16'(in_ready), 16'(m_ready()));
      chk("R4", "out_valid", 16'(out_valid), 16'(m_rq.size() > 0));
      if (m_rq.size() > 0) chk("R9", "out_data", 16'(out_data), 16'(m_rq[0]));
      chk("R2", "lo_out", 16'(lo_out), 16'(m_lo));
      chk("R2", "lo_oe", 16'(lo_oe), 16'(m_loe));
      chk("R3", "hi_out", 16'(hi_out), 16'(m_hi));
      chk("R3", "hi_oe", 16'(hi_oe), 16'(m_hoe));
      chk("R8", "loop_en", 16'(loop_en), 16'(m_loop));
      chk("R7", "sh_valid", 16'(sh_valid), 16'(m_disp));
      if (m_disp) begin
        chk("R5", "sh_op", 16'(sh_op), 16'(m_op));
        chk("R6", "sh_len", sh_len, m_len);
      end
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    vectors++;
    chk("R1", "in_ready", 16'(in_ready), 16'h1);
    chk("R1", "out_valid", 16'(out_valid), 16'h0);
    chk("R1", "sh_valid", 16'(sh_valid), 16'h0);
    chk("R1", "loop_en", 16'(loop_en), 16'h0);
    chk("R1", "pins", {lo_out | lo_oe, hi_out | hi_oe}, 16'h0);

    // R2, R3: pin group writes
    send(8'h80); send(8'hA5); send(8'h0F);
    send(8'h82); send(8'h3C); send(8'hF0);
    // R4 with R10 back-pressure
    out_bp = 1'b1;
    lo_pins = 8'h5A; hi_pins = 8'hC3;
    send(8'h81); send(8'h83);
    // R8
    send(8'h84); send(8'h85);
    // R11: operand bytes shaped like loopback opcodes
    send(8'h80); send(8'h85); send(8'hFF);
    send(8'h84);
    send(8'h82); send(8'h85); send(8'h00);
    send(8'h85);
    // R5 byte-mode then immediate next byte to stall (R7)
    send(8'h11); send(8'h34); send(8'h12);
    send(8'h81);
    // R6 bit-mode
    send(8'h13); send(8'h05);
    send(8'h3B); send(8'h80);
    // R9 unknown opcodes back to back, then resync
    send(8'h86); send(8'hFF); send(8'h83);
    out_bp = 1'b0;
    // Mixed pseudo-random stream
    r = 32'h1234_5678;
    for (int i = 0; i < 120; i++) begin
      r = r * 32'd1103515245 + 32'd12345;
      lo_pins = r[31:24];
      hi_pins = r[15:8];
      if (i == 60) out_bp = 1'b1;
      send(r[23:16]);
    end
    out_bp = 1'b0;
    repeat (30) @(negedge clk);
    finish_run();
  end
endmodule